// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a set of general-purpose input pins split into three groups (eight, seven and eight pins) and raises a per-group interrupt flag when any enabled pin in a group changes level, in either direction. Each pin input goes through a two-flop synchronizer. A change is found by comparing the synchronized value with the value one cycle older.

Software sets up the block through a small byte-wide register port. There is one mask register per group, with one bit per pin. A group enable register holds one bit per group. A flag register shows the pending groups, and writing a one to a flag bit clears it. A per-group acknowledge input from the interrupt sequencer also clears that group's flag. Each group drives its own registered interrupt request. A request is asserted only while that group's flag and enable bit are set and the global interrupt enable input is high.

Pin `k` of group 0 is `pins[k]`, pin `k` of group 1 is `pins[8+k]` and pin `k` of group 2 is `pins[15+k]`. The register addresses are: 0, 1 and 2 for the masks of groups 0, 1 and 2; 3 for the group enable register (bit g is group g); 4 for the flag register (bit g is group g).

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: A rising or a falling change on a pin whose mask bit is one, in a group whose enable bit is one, sets that group's flag. The flag stays set until it is cleared.
- R2: `irq[g]` is one exactly when, at the previous clock edge, flag g was one, enable bit g was one and `gie` was one.
- R3: A one on `ack[g]` for one cycle clears flag g only. The flags of the other groups are unchanged.
- R4: Writing address 4 clears each flag whose `wdata` bit is one. A zero bit leaves the flag as it was.
- R5: A pin change has no effect when the pin's mask bit is zero, or when its group's enable bit is zero.
- R6: Bit 7 of the group 1 mask (address 1) always reads as zero. Bits 7:3 of addresses 3 and 4 always read as zero.
- R7: After reset, all mask bits, enable bits, flags, `irq` and `rd_data` are zero.
- R8: If a qualifying change and a clear (acknowledge or write-one) hit the same flag in the same cycle, the flag ends at one.
- R9: `rd_data` presents the register chosen by `addr` one clock edge after `addr` is applied. Writes with `we` high take effect at the next clock edge.
- R10: After a pin change applied between clock edges, the flag is set at the third rising edge and `irq` rises at the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 23 | Asynchronous pin inputs, groups packed from bit 0 upward |
| gie | input | 1 | Global interrupt enable |
| ack | input | 3 | Per-group acknowledge pulse, clears that group's flag |
| addr | input | 4 | Register address |
| we | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 3 | Per-group registered interrupt request |

## Verification
The assertions assume that `rst` is held for at least one edge from time zero, and that `ack` is a single-cycle pulse driven synchronously with the clock. They also assume that `addr` and `we` change only between edges. The bench drives every input at the falling edge and keeps pins stable long enough for each change to pass the synchronizer. Random operations are spaced so that the model can apply each one on its own. Directed sequences then line up a pin change with an acknowledge at an exact edge to cover the case where set and clear collide.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int unsigned NGRP   = 3;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 4;

  // pins per group
  function automatic int unsigned grp_w(input int unsigned g);
    case (g)
      0:       return 8;
      1:       return 7;
      default: return 8;
    endcase
  endfunction

  // lowest pin index of a group
  function automatic int unsigned grp_lo(input int unsigned g);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < g; i++) s += grp_w(i);
    return s;
  endfunction

  localparam int unsigned NPIN = grp_lo(NGRP);

  // register map
  localparam int unsigned A_MASK0 = 0;
  localparam int unsigned A_EN    = NGRP;
  localparam int unsigned A_FLAG  = NGRP + 1;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] chg
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q[i]   <= 1'b0;
        s2_q[i]   <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        s1_q[i]   <= din[i];
        s2_q[i]   <= s1_q[i];
        prev_q[i] <= s2_q[i];
      end
    end
    assign chg[i] = s2_q[i] ^ prev_q[i];
  end

  // a reported change must be followed by the old value catching up (R10)
  p_chg_settle_r10: assert property (@(posedge clk) disable iff (rst)
    (chg != '0) |=> (prev_q == $past(s2_q)));
endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] chg,
  input  logic [W-1:0] mask,
  input  logic         grp_en,
  input  logic         ack,
  input  logic         sw_clr,
  output logic         flag
);
  logic hit;
  assign hit = grp_en & (|(chg & mask));

  always_ff @(posedge clk) begin
    if (rst)                flag <= 1'b0;
    else if (hit)           flag <= 1'b1;   // set has priority
    else if (ack || sw_clr) flag <= 1'b0;
  end

  p_set_r1: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && (ack || sw_clr)) |=> flag);
  p_ack_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit) |=> !flag);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    (!flag && !(grp_en && (chg & mask) != '0)) |=> !flag);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (flag && !ack && !sw_clr) |=> flag);
endmodule

// File: rtl/pcint_regs.sv
module pcint_regs
  import pcint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NGRP-1:0]   flags,
  output logic [NPIN-1:0]   mask_q,
  output logic [NGRP-1:0]   en_q,
  output logic [NGRP-1:0]   sw_clr,
  output logic [REG_W-1:0]  rd_data
);
  logic [REG_W-1:0] mask_word [NGRP];
  logic [REG_W-1:0] rd_mux;

  for (genvar g = 0; g < NGRP; g++) begin : g_mask
    localparam int unsigned W  = grp_w(g);
    localparam int unsigned LO = grp_lo(g);
    always_ff @(posedge clk) begin
      if (rst)
        mask_q[LO +: W] <= '0;
      else if (we && addr == ADDR_W'(A_MASK0 + g))
        mask_q[LO +: W] <= wdata[W-1:0];
    end
    assign mask_word[g] = REG_W'(mask_q[LO +: W]);
  end

  always_ff @(posedge clk) begin
    if (rst)                            en_q <= '0;
    else if (we && addr == ADDR_W'(A_EN)) en_q <= wdata[NGRP-1:0];
  end

  assign sw_clr = (we && addr == ADDR_W'(A_FLAG)) ? wdata[NGRP-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    for (int unsigned g = 0; g < NGRP; g++)
      if (addr == ADDR_W'(A_MASK0 + g)) rd_mux = mask_word[g];
    if (addr == ADDR_W'(A_EN))   rd_mux = REG_W'(en_q);
    if (addr == ADDR_W'(A_FLAG)) rd_mux = REG_W'(flags);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && en_q == '0 && rd_data == '0));
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(A_MASK0 + 1)) |-> (rd_data[REG_W-1] == 1'b0));
  p_read_lat_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(A_EN)) |-> (rd_data == REG_W'($past(en_q))));
endmodule

// File: rtl/pinchg_irq_ctrl.sv
module pinchg_irq_ctrl
  import pcint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pins,
  input  logic              gie,
  input  logic [NGRP-1:0]   ack,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rd_data,
  output logic [NGRP-1:0]   irq
);
  logic [NPIN-1:0] chg;
  logic [NPIN-1:0] mask_q;
  logic [NGRP-1:0] en_q;
  logic [NGRP-1:0] sw_clr;
  logic [NGRP-1:0] flag;

  pcint_sync #(.W(NPIN)) u_sync (
    .clk (clk), .rst (rst), .din (pins), .chg (chg)
  );

  pcint_regs u_regs (
    .clk (clk), .rst (rst), .addr (addr), .we (we), .wdata (wdata),
    .flags (flag), .mask_q (mask_q), .en_q (en_q), .sw_clr (sw_clr),
    .rd_data (rd_data)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned W  = grp_w(g);
    localparam int unsigned LO = grp_lo(g);
    pcint_group #(.W(W)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .chg    (chg[LO +: W]),
      .mask   (mask_q[LO +: W]),
      .grp_en (en_q[g]),
      .ack    (ack[g]),
      .sw_clr (sw_clr[g]),
      .flag   (flag[g])
    );

    p_irq_gate_r2: assert property (@(posedge clk) disable iff (rst)
      irq[g] |-> $past(gie && en_q[g] && flag[g]));
    p_irq_on_r2: assert property (@(posedge clk) disable iff (rst)
      (gie && en_q[g] && flag[g]) |=> irq[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= flag & en_q & {NGRP{gie}};
  end
endmodule

// File: tb/pinchg_irq_ctrl_tb.sv
module pinchg_irq_ctrl_tb;
  import pcint_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NPIN-1:0]   pins = '0;
  logic              gie = 1'b0;
  logic [NGRP-1:0]   ack = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [REG_W-1:0]  wdata = '0;
  logic [REG_W-1:0]  rd_data;
  logic [NGRP-1:0]   irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model
  logic [NPIN-1:0] m_mask = '0;
  logic [NGRP-1:0] m_en = '0;
  logic [NGRP-1:0] m_flag = '0;

  always #2 clk = ~clk;

  pinchg_irq_ctrl u_dut (
    .clk (clk), .rst (rst), .pins (pins), .gie (gie), .ack (ack),
    .addr (addr), .we (we), .wdata (wdata), .rd_data (rd_data), .irq (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NGRP-1:0] grp_hits(input logic [NPIN-1:0] diff);
    logic [NGRP-1:0] h;
    for (int g = 0; g < NGRP; g++) begin
      h[g] = 1'b0;
      for (int k = 0; k < NPIN; k++)
        if (k >= grp_lo(g) && k < grp_lo(g) + grp_w(g) && diff[k] && m_mask[k])
          h[g] = 1'b1;
    end
    return h & m_en;
  endfunction

  task automatic wr_mask(input int g, input logic [7:0] d);
    wr(A_MASK0 + g, d);
    for (int k = 0; k < grp_w(g); k++) m_mask[grp_lo(g) + k] = d[k];
  endtask

  task automatic toggle(input logic [NPIN-1:0] t);
    @(negedge clk);
    m_flag = m_flag | grp_hits(t);
    pins = pins ^ t;
    idle(5);
  endtask

  task automatic check_state(input string req);
    logic [7:0] d;
    rd(A_FLAG, d);
    check({req, " flag"}, 32'(d), 32'(m_flag));
    check({req, " irq"}, 32'(irq), 32'(m_flag & m_en & {NGRP{gie}}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R7 reset state
    check("R7 irq", 32'(irq), 0);
    check("R7 rd_data", 32'(rd_data), 0);
    for (int a = 0; a <= A_FLAG; a++) begin
      rd(a, d);
      check("R7 reg", 32'(d), 0);
    end

    // R6 / R9 reserved bits and read-back
    wr_mask(1, 8'hFF);
    rd(1, d); check("R6 mask1 bit7", 32'(d), 32'h7F);
    wr(A_EN, 8'hFF); m_en = '1;
    rd(A_EN, d); check("R6 enable upper", 32'(d), 32'h07);
    wr_mask(0, 8'hA5);
    rd(0, d); check("R9 mask0 readback", 32'(d), 32'hA5);
    wr_mask(2, 8'h3C);
    rd(2, d); check("R9 mask2 readback", 32'(d), 32'h3C);

    // R5 masked pin ignored: pin1 of group 0 (mask bit 1 = 0)
    toggle(NPIN'(1) << 1);
    check_state("R5 masked pin");
    // R5 group disabled
    wr(A_EN, 8'h06); m_en = 3'b110;
    toggle(NPIN'(1) << 0);
    check_state("R5 group disabled");

    // R1 rising then falling on group 2 pin 2 (pins[17])
    gie = 1'b1;
    toggle(NPIN'(1) << 17);
    check_state("R1 rise");
    wr(A_FLAG, 8'h04); m_flag[2] = 1'b0;
    toggle(NPIN'(1) << 17);
    check_state("R1 fall");

    // R4 write zero no effect, write one clears
    wr(A_FLAG, 8'h00);
    check_state("R4 write zero");
    wr(A_FLAG, 8'hFB); m_flag = m_flag & 3'b100;
    check_state("R4 write one other bits");
    wr(A_FLAG, 8'h04); m_flag = '0;
    check_state("R4 write one");

    // R3 ack clears only its group
    toggle((NPIN'(1) << 8) | (NPIN'(1) << 17));
    check_state("R3 setup");
    @(negedge clk) ack = 3'b010;
    @(negedge clk) ack = 3'b000;
    m_flag[1] = 1'b0;
    idle(2);
    check_state("R3 ack group1");

    // R2 gie off masks irq
    gie = 1'b0; idle(2);
    check_state("R2 gie low");
    gie = 1'b1; idle(2);
    check_state("R2 gie high");
    wr(A_FLAG, 8'h07); m_flag = '0;

    // R10 latency and R8 collision, group 0 pin 0
    wr(A_EN, 8'h07); m_en = '1;
    wr_mask(0, 8'h01);
    @(negedge clk) pins[0] = ~pins[0];
    @(negedge clk);                // after edge 1
    @(negedge clk) ack = 3'b001;   // after edge 2, sampled at edge 3
    @(negedge clk) ack = 3'b000;   // after edge 3: flag set, irq still 0
    check("R10 irq after edge3", 32'(irq[0]), 0);
    @(negedge clk);
    check("R10 irq after edge4", 32'(irq[0]), 1);
    m_flag[0] = 1'b1;
    check_state("R8 set wins over ack");
    // R8 with write-one clear in the colliding cycle
    wr(A_FLAG, 8'h01); m_flag = '0;
    @(negedge clk) pins[0] = ~pins[0];
    @(negedge clk);
    @(negedge clk) begin addr = ADDR_W'(A_FLAG); wdata = 8'h01; we = 1'b1; end
    @(negedge clk) we = 1'b0;
    m_flag[0] = 1'b1;
    check_state("R8 set wins over write");
    wr(A_FLAG, 8'h07); m_flag = '0;

    // random phase
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin
          int g;
          g = int'($urandom_range(0, NGRP - 1));
          wr_mask(g, 8'($urandom));
        end
        1: begin
          logic [7:0] e;
          e = 8'($urandom);
          wr(A_EN, e); m_en = e[NGRP-1:0];
        end
        2: begin
          logic [7:0] c;
          c = 8'($urandom);
          wr(A_FLAG, c); m_flag = m_flag & ~c[NGRP-1:0];
        end
        3: begin
          logic [NGRP-1:0] a;
          a = NGRP'($urandom);
          @(negedge clk) ack = a;
          @(negedge clk) ack = '0;
          m_flag = m_flag & ~a;
        end
        4: gie = 1'($urandom);
        default: toggle(NPIN'($urandom));
      endcase
      idle(2);
      check_state("R1 R2 R3 R4 R5 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule